// File: doc/BRIEF.md
# EPP Host Port to Byte FIFO Bridge

This block connects a host parallel port running in EPP mode to two external byte-wide FIFOs. It uses one system clock. When the host runs a write cycle, the byte on the shared bus goes into the receive FIFO. When the host runs a read cycle, one byte is taken from the transmit FIFO and placed on the bus. The address strobe and the data strobe start the same action, so the host can use either one. No register is decoded.

The host strobes and the direction line are asynchronous to the system clock, so each is synchronised before the state machine sees it. The acknowledge line (`pp_wait`) provides flow control. It stays low while a cycle cannot finish: on a write while the receive FIFO is full, or on a read while the transmit FIFO is empty. It rises only after the FIFO access is done. It then stays high until the host releases its strobe, so one strobe never causes more than one FIFO access.

The transmit FIFO is a standard FIFO, not a fall-through one. Its data is therefore captured on the clock after the read pulse, and only then is the cycle acknowledged.

Top module: `epp_fifo_bridge`

## Requirements
- R1: While `rst_n` is low (asynchronous, active-low), `pp_wait` is 0, `rxq_wr` is 0 and `txq_rd` is 0.
- R2: A write cycle is `pp_write_n` low with `pp_astb_n` or `pp_dstb_n` low. Either strobe gives exactly one `rxq_wr` pulse, and `rxq_data` then equals the byte the host placed on `pp_data`.
- R3: A read cycle is `pp_write_n` high with either strobe low. Either strobe gives exactly one `txq_rd` pulse. The byte the FIFO presents on the clock after that pulse is the byte driven on `pp_data` while `pp_wait` is high.
- R4: The block drives `pp_data` only while it acknowledges a read cycle. At all other times `pp_data` is high-impedance, so host write bytes pass through unchanged.
- R5: A write cycle started while `rxq_full` is 1 gives no `rxq_wr` and keeps `pp_wait` at 0 until `rxq_full` falls. The cycle then completes normally.
- R6: A read cycle started while `txq_empty` is 1 gives no `txq_rd` and keeps `pp_wait` at 0 until `txq_empty` falls. The cycle then completes normally.
- R7: Once `pp_wait` has risen, it stays at 1 for as long as the host holds its strobe low. No further FIFO access happens during that time.
- R8: Each `rxq_wr` and `txq_rd` pulse lasts exactly one clock, and the two are never high in the same clock.
- R9: Strobes pass through a two-flop synchroniser. With the FIFO ready, the access pulse is high in the third clock after the strobe falls. `pp_wait` rises one clock after a write pulse and two clocks after a read pulse.
- R10: `pp_wait` returns to 0 in the third clock after the host releases the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active-low |
| pp_data | inout | 8 | Host bidirectional byte bus |
| pp_astb_n | input | 1 | Host address strobe, active-low |
| pp_dstb_n | input | 1 | Host data strobe, active-low |
| pp_write_n | input | 1 | Host direction, low for a write |
| pp_wait | output | 1 | Handshake: high acknowledges the current cycle |
| txq_rd | output | 1 | One-clock read pulse to the transmit FIFO |
| txq_empty | input | 1 | Transmit FIFO has no data |
| txq_data | input | 8 | Transmit FIFO read data, valid the clock after `txq_rd` |
| rxq_wr | output | 1 | One-clock write pulse to the receive FIFO |
| rxq_full | input | 1 | Receive FIFO has no space |
| rxq_data | output | 8 | Byte written to the receive FIFO |

## Verification
A wrong state in the handshake machine shows at the ports within a clock or two:
- A stuck or skipped state either moves the `pp_wait` rising edge away from its fixed clock after the strobe, or doubles or drops an access pulse.

A bad capture shows only when the host samples the bus during the acknowledge:
- Capturing the transmit data one clock early puts the wrong byte on `pp_data`.

A corrupted write byte shows as the wrong entry in the receive FIFO.

Lost flow control shows as an access pulse while the FIFO reports full or empty, or as `pp_wait` rising while the FIFO still blocks.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CAPT,
        ST_ACK
    } bridge_st_e;

    typedef struct packed {
        logic strobe;
        logic write;
    } host_req_t;

    function automatic host_req_t decode_req(input logic astb_n, input logic dstb_n,
                                             input logic write_n);
        host_req_t r;
        r.strobe = !astb_n || !dstb_n;
        r.write  = !write_n;
        return r;
    endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d_in[b]};
        end
        assign d_out[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/epp_fsm.sv
module epp_fsm
    import epp_bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_req_t req,
    input  logic      rxq_full,
    input  logic      txq_empty,
    output logic      rxq_wr,
    output logic      txq_rd,
    output logic      ack,
    output logic      bus_oe,
    output logic      load_rx,
    output logic      load_tx
);
    bridge_st_e st, nxt;
    logic       rd_dir;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (req.strobe) begin
                if (req.write) begin
                    if (!rxq_full) nxt = ST_PUSH;
                end else if (!txq_empty) begin
                    nxt = ST_POP;
                end
            end
            ST_PUSH: nxt = ST_ACK;
            ST_POP:  nxt = ST_CAPT;
            ST_CAPT: nxt = ST_ACK;
            ST_ACK:  if (!req.strobe) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            rd_dir <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && nxt == ST_POP)  rd_dir <= 1'b1;
            if (st == ST_IDLE && nxt == ST_PUSH) rd_dir <= 1'b0;
        end
    end

    assign rxq_wr  = (st == ST_PUSH);
    assign txq_rd  = (st == ST_POP);
    assign ack     = (st == ST_ACK);
    assign bus_oe  = (st == ST_ACK) && rd_dir;
    assign load_rx = (st == ST_IDLE) && (nxt == ST_PUSH);
    assign load_tx = (st == ST_CAPT);
endmodule

// File: rtl/epp_datapath.sv
module epp_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_rx,
    input  logic         load_tx,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] txq_data,
    output logic [W-1:0] rxq_data,
    output logic [W-1:0] tx_hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxq_data <= '0;
            tx_hold  <= '0;
        end else begin
            if (load_rx) rxq_data <= bus_in;
            if (load_tx) tx_hold  <= txq_data;
        end
    end
endmodule

// File: rtl/epp_fifo_bridge.sv
module epp_fifo_bridge
    import epp_bridge_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    inout  wire  [W-1:0] pp_data,
    input  logic         pp_astb_n,
    input  logic         pp_dstb_n,
    input  logic         pp_write_n,
    output logic         pp_wait,
    output logic         txq_rd,
    input  logic         txq_empty,
    input  logic [W-1:0] txq_data,
    output logic         rxq_wr,
    input  logic         rxq_full,
    output logic [W-1:0] rxq_data
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_s;
    host_req_t       req;
    logic            bus_oe, load_rx, load_tx;
    logic [W-1:0]    tx_hold;

    epp_sync #(.N(NCTL), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({pp_astb_n, pp_dstb_n, pp_write_n}),
        .d_out (ctl_s)
    );

    assign req = decode_req(ctl_s[2], ctl_s[1], ctl_s[0]);

    epp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .rxq_full  (rxq_full),
        .txq_empty (txq_empty),
        .rxq_wr    (rxq_wr),
        .txq_rd    (txq_rd),
        .ack       (pp_wait),
        .bus_oe    (bus_oe),
        .load_rx   (load_rx),
        .load_tx   (load_tx)
    );

    epp_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rx  (load_rx),
        .load_tx  (load_tx),
        .bus_in   (pp_data),
        .txq_data (txq_data),
        .rxq_data (rxq_data),
        .tx_hold  (tx_hold)
    );

    assign pp_data = bus_oe ? tx_hold : {W{1'bz}};
endmodule

// File: rtl/epp_fifo_bridge_chk.sv
module epp_fifo_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic pp_astb_n,
    input logic pp_dstb_n,
    input logic pp_wait,
    input logic txq_rd,
    input logic txq_empty,
    input logic rxq_wr,
    input logic rxq_full,
    input logic bus_oe
);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(txq_rd && rxq_wr));
    p_wr_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_wr |=> !rxq_wr);
    p_rd_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txq_rd |=> !txq_rd);
    p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_wr |-> $past(!rxq_full));
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txq_rd |-> $past(!txq_empty));
    p_drive_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> pp_wait);
    p_capture_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txq_rd |=> !pp_wait);
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pp_wait) |-> $past(pp_astb_n && pp_dstb_n, 2));
    p_no_access_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pp_wait |-> !rxq_wr && !txq_rd);
endmodule

bind epp_fifo_bridge epp_fifo_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pp_astb_n (pp_astb_n),
    .pp_dstb_n (pp_dstb_n),
    .pp_wait   (pp_wait),
    .txq_rd    (txq_rd),
    .txq_empty (txq_empty),
    .rxq_wr    (rxq_wr),
    .rxq_full  (rxq_full),
    .bus_oe    (bus_oe)
);

// File: tb/sim_epp_fifo_bridge.sv
`timescale 1ns/1ps
module sim_epp_fifo_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       astb_n = 1'b1, dstb_n = 1'b1, write_n = 1'b1;
    logic       host_oe = 1'b0;
    logic [7:0] host_byte = 8'h00;
    wire  [7:0] pp_bus;
    logic       pp_wait, txq_rd, rxq_wr;
    logic       txq_empty = 1'b1;
    logic [7:0] txq_data = 8'h00;
    logic       rxq_full = 1'b0;
    logic [7:0] rxq_data;

    int checks = 0, fails = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_got[$];
    bit pop_due = 0;
    int rd_pulses = 0, wr_pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign pp_bus = host_oe ? host_byte : 8'bz;

    epp_fifo_bridge u0 (
        .clk(clk), .rst_n(rst_n), .pp_data(pp_bus),
        .pp_astb_n(astb_n), .pp_dstb_n(dstb_n), .pp_write_n(write_n),
        .pp_wait(pp_wait), .txq_rd(txq_rd), .txq_empty(txq_empty),
        .txq_data(txq_data), .rxq_wr(rxq_wr), .rxq_full(rxq_full),
        .rxq_data(rxq_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 push, 2 pop, 3 capture, 4 acknowledge
    int   m_ph = 0;
    bit   m_s1 = 0, m_s2 = 0, m_w1 = 0, m_w2 = 0, m_rd = 0;
    logic [7:0] m_hold = 8'h00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_s1 = 0; m_s2 = 0; m_w1 = 0; m_w2 = 0; m_rd = 0;
        end else begin
            if (m_ph == 0) begin
                if (m_s2) begin
                    if (m_w2) begin
                        if (!rxq_full) begin m_ph = 1; m_rd = 0; end
                    end else if (!txq_empty) begin
                        m_ph = 2; m_rd = 1;
                    end
                end
            end else if (m_ph == 1) m_ph = 4;
            else if (m_ph == 2) m_ph = 3;
            else if (m_ph == 3) begin m_hold = txq_data; m_ph = 4; end
            else if (m_ph == 4 && !m_s2) m_ph = 0;
            m_s2 = m_s1; m_s1 = !astb_n || !dstb_n;
            m_w2 = m_w1; m_w1 = !write_n;
            if (pop_due) begin
                txq_data <= tx_q.pop_front();
                pop_due = 0;
            end
            txq_empty <= (tx_q.size() == 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pp_wait == (m_ph == 4) && rxq_wr == (m_ph == 1) && txq_rd == (m_ph == 2),
                  "R7 R8 R9 R10 cycle model", {pp_wait, rxq_wr, txq_rd},
                  {m_ph == 4, m_ph == 1, m_ph == 2});
            if (m_ph == 4 && m_rd)
                check(pp_bus == m_hold, "R3 bus byte", pp_bus, m_hold);
            if (rxq_wr) begin rx_got.push_back(rxq_data); wr_pulses++; end
            if (txq_rd) begin pop_due = 1; rd_pulses++; end
        end
    end

    task automatic set_strobe(input bit use_addr, input logic v);
        if (use_addr) astb_n = v; else dstb_n = v;
    endtask

    task automatic host_write(input logic [7:0] b, input bit use_addr, input int hold);
        @(negedge clk);
        host_oe = 1; host_byte = b; write_n = 0;
        set_strobe(use_addr, 1'b0);
        while (!pp_wait) @(negedge clk);
        repeat (hold) @(negedge clk);
        set_strobe(use_addr, 1'b1);
        while (pp_wait) @(negedge clk);
        write_n = 1; host_oe = 0;
    endtask

    task automatic host_read(input bit use_addr, output logic [7:0] got);
        @(negedge clk);
        write_n = 1;
        set_strobe(use_addr, 1'b0);
        while (!pp_wait) @(negedge clk);
        got = pp_bus;
        set_strobe(use_addr, 1'b1);
        while (pp_wait) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_q.push_back(b);
        txq_empty = 1'b0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] got;
        int n, wr0, rd0;
        repeat (3) @(negedge clk);
        check(pp_wait == 0 && rxq_wr == 0 && txq_rd == 0, "R1 reset outputs",
              {pp_wait, rxq_wr, txq_rd}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R4: writes through both strobes
        host_write(8'hA5, 0, 0);
        host_write(8'h3C, 1, 0);
        check(rx_got.size() == 2, "R2 write count", rx_got.size(), 2);
        if (rx_got.size() == 2) begin
            check(rx_got[0] == 8'hA5, "R2 R4 data strobe byte", rx_got[0], 8'hA5);
            check(rx_got[1] == 8'h3C, "R2 R4 address strobe byte", rx_got[1], 8'h3C);
        end

        // R3: reads through both strobes
        push_tx(8'h11); push_tx(8'h22);
        host_read(0, got); check(got == 8'h11, "R3 read via data strobe", got, 8'h11);
        host_read(1, got); check(got == 8'h22, "R3 read via address strobe", got, 8'h22);
        check(rd_pulses == 2, "R3 one pop per read", rd_pulses, 2);

        // R6: read while empty
        rd0 = rd_pulses;
        fork
            host_read(0, got);
            begin
                repeat (20) @(negedge clk);
                check(pp_wait == 0, "R6 wait held while empty", pp_wait, 0);
                check(rd_pulses == rd0, "R6 no pop while empty", rd_pulses, rd0);
                push_tx(8'h77);
            end
        join
        check(got == 8'h77, "R6 read completes", got, 8'h77);

        // R5: write while full
        rxq_full = 1;
        wr0 = wr_pulses;
        fork
            host_write(8'h5A, 1, 0);
            begin
                repeat (20) @(negedge clk);
                check(pp_wait == 0, "R5 wait held while full", pp_wait, 0);
                check(wr_pulses == wr0, "R5 no push while full", wr_pulses, wr0);
                rxq_full = 0;
            end
        join
        check(wr_pulses == wr0 + 1 && rx_got[$] == 8'h5A, "R5 write completes",
              rx_got[$], 8'h5A);

        // R7: long strobe hold gives one access
        wr0 = wr_pulses;
        host_write(8'hC3, 0, 15);
        check(wr_pulses == wr0 + 1, "R7 single push on long strobe", wr_pulses, wr0 + 1);

        // R9 R10: latency
        @(negedge clk);
        host_oe = 1; host_byte = 8'h99; write_n = 0; dstb_n = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!rxq_wr && n < 10);
        check(n == 3, "R9 push latency", n, 3);
        @(negedge clk);
        check(pp_wait == 1, "R9 ack one clock after push", pp_wait, 1);
        dstb_n = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (pp_wait && n < 10);
        check(n == 3, "R10 release latency", n, 3);
        write_n = 1; host_oe = 0;

        push_tx(8'h42);
        @(negedge clk);
        astb_n = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!txq_rd && n < 10);
        check(n == 3, "R9 pop latency", n, 3);
        @(negedge clk);
        check(pp_wait == 0, "R9 capture clock before ack", pp_wait, 0);
        @(negedge clk);
        check(pp_wait == 1 && pp_bus == 8'h42, "R9 R3 ack two clocks after pop",
              pp_bus, 8'h42);
        astb_n = 1;
        while (pp_wait) @(negedge clk);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule